// File: doc/BRIEF.md
# Packed 16-bit SIMD Multiply Unit

This block multiplies two 64-bit operands lane by lane. Each operand holds four independent 16-bit lanes, and each lane pair goes through its own full 16×16 multiplier that always produces the 32-bit signed product. A one-bit operation select then keeps one half of that product for the destination lane. The low half is the same whether the inputs are read as signed or unsigned. The high half is that of the two's-complement product.

The unit is a fixed three-stage pipeline. It takes a new operation on every clock with no stall. The operation select travels down the pipeline next to the data, so neighbouring operations may use different modes. An output strobe marks the cycle in which each result appears. The block sits between an operand source and a result sink that both run at the full rate.

Top module: `pmul_top`

## Requirements
- R1: Lane i of `out_data` (bits [16i+15:16i], lane 0 at bits [15:0], lane 3 at bits [63:48]) depends only on lane i of `in_a` and `in_b`.
- R2: With `in_op` = 0 (low mode), each result lane equals bits [15:0] of the lane product.
- R3: With `in_op` = 1 (high mode), each result lane equals bits [31:16] of the product of the two lanes read as signed two's-complement values. For example, 0x8000 × 0x8000 gives 0x4000, while low mode gives 0x0000 for the same lanes.
- R4: `out_valid` equals `in_valid` from exactly three clock edges earlier, and `out_data` carries that operation's result in the same cycle. Idle input cycles produce idle output cycles.
- R5: An operation is accepted on every cycle that `in_valid` is high, with no stall, and the mode may change from one cycle to the next without corrupting either result.
- R6: While `rst_n` is low, every pipeline valid bit is cleared at once, and `out_valid` stays low until an operation accepted after reset has had time to reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 1 | 0 = keep low half, 1 = keep signed high half |
| in_a | input | 64 | First operand, four 16-bit lanes |
| in_b | input | 64 | Second operand, four 16-bit lanes |
| out_valid | output | 1 | A result is presented this cycle |
| out_data | output | 64 | Result, four 16-bit lanes |

## Verification
The bench builds the unit with its default shape: four lanes of 16 bits and a three-stage pipeline. This puts every sign corner of a lane within reach: the minimum negative value, all ones, and the largest positive value. It can put a different corner value in each lane at the same time, so a swap between lanes or a shift across lanes changes some lane's expected result. At this latency the bench can fill the pipeline with operations whose modes alternate every cycle, and it can also leave bubbles, so a mode or valid bit that drifts by one stage shows up as a wrong half or a misplaced strobe.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  localparam int unsigned LANE_W  = 16;
  localparam int unsigned N_LANES = 4;
  localparam int unsigned PIPE_D  = 3;

  typedef enum logic {
    OP_LO = 1'b0,
    OP_HI = 1'b1
  } pmul_op_e;
endpackage

// File: rtl/pmul_ctl_pipe.sv
module pmul_ctl_pipe
  import pmul_pkg::*;
#(
  parameter int unsigned DEPTH = PIPE_D
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     vld_i,
  input  pmul_op_e op_i,
  output logic     vld_s1_o,
  output logic     vld_s2_o,
  output pmul_op_e op_s2_o,
  output logic     vld_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic     vld_q [DEPTH];
  logic     vld_d [DEPTH];
  pmul_op_e op_q  [DEPTH];
  pmul_op_e op_d  [DEPTH];
  logic     op_en [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_comb begin
      if (k == 0) begin
        vld_d[k] = vld_i;
        op_d[k]  = op_i;
        op_en[k] = vld_i;
      end else begin
        vld_d[k] = vld_q[k-1];
        op_d[k]  = op_q[k-1];
        op_en[k] = vld_q[k-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[k] <= 1'b0;
      else        vld_q[k] <= vld_d[k];
    end

    always_ff @(posedge clk) begin
      if (op_en[k]) op_q[k] <= op_d[k];
    end
  end

  assign vld_s1_o = vld_q[0];
  assign vld_s2_o = vld_q[1];
  assign op_s2_o  = op_q[1];
  assign vld_o    = vld_q[DEPTH-1];

  // Cycles since reset release, saturating at DEPTH (checker only)
  logic [CNT_W-1:0] since_rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      since_rst_q <= '0;
    else if (since_rst_q != DEPTH[CNT_W-1:0]) since_rst_q <= since_rst_q + 1'b1;
  end

  assert_quiet_after_reset_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q < DEPTH[CNT_W-1:0]) |-> !vld_o);

  assert_first_stage_tracks_input_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q != '0) |-> (vld_q[0] == $past(vld_i)));

  for (genvar k = 1; k < DEPTH; k++) begin : g_chk
    assert_stage_advance_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst_q > k[CNT_W-1:0]) |-> (vld_q[k] == $past(vld_q[k-1])));
  end
endmodule

// File: rtl/pmul_lane.sv
module pmul_lane
  import pmul_pkg::*;
#(
  parameter int unsigned W = LANE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_s1_i,
  input  logic         en_s2_i,
  input  logic         en_s3_i,
  input  pmul_op_e     op_s2_i,
  input  pmul_op_e     op_i,
  input  logic         vld_out_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0]  a_q, b_q;
  logic [PW-1:0] prod_d, prod_q;
  logic [W-1:0]  res_d, res_q;

  // Stage 1: capture operands
  always_ff @(posedge clk) begin
    if (en_s1_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  // Stage 2: full signed product
  always_comb prod_d = PW'($signed(a_q) * $signed(b_q));

  always_ff @(posedge clk) begin
    if (en_s2_i) prod_q <= prod_d;
  end

  // Stage 3: keep one half
  always_comb begin
    unique case (op_s2_i)
      OP_HI:   res_d = prod_q[PW-1:W];
      default: res_d = prod_q[W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (en_s3_i) res_q <= res_d;
  end

  assign res_o = res_q;

  // Checker: relate the lane output to the lane inputs three edges back
  logic [PW-1:0] ref_full;
  always_comb ref_full = PW'($signed(a_i) * $signed(b_i));

  assert_low_half_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (vld_out_i && $past(op_i, 3) == OP_LO) |-> (res_o == $past(ref_full[W-1:0], 3)));

  assert_high_half_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (vld_out_i && $past(op_i, 3) == OP_HI) |-> (res_o == $past(ref_full[PW-1:W], 3)));
endmodule

// File: rtl/pmul_top.sv
module pmul_top
  import pmul_pkg::*;
#(
  parameter int unsigned LW = LANE_W,
  parameter int unsigned NL = N_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_op,
  input  logic [LW*NL-1:0] in_a,
  input  logic [LW*NL-1:0] in_b,
  output logic             out_valid,
  output logic [LW*NL-1:0] out_data
);
  localparam int unsigned LAT = PIPE_D;

  logic     vld_s1, vld_s2, vld_s3;
  pmul_op_e op_s2;
  pmul_op_e op_in;

  assign op_in = pmul_op_e'(in_op);

  pmul_ctl_pipe #(.DEPTH(LAT)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_i    (in_valid),
    .op_i     (op_in),
    .vld_s1_o (vld_s1),
    .vld_s2_o (vld_s2),
    .op_s2_o  (op_s2),
    .vld_o    (vld_s3)
  );

  for (genvar i = 0; i < NL; i++) begin : g_lane
    pmul_lane #(.W(LW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_s1_i   (in_valid),
      .en_s2_i   (vld_s1),
      .en_s3_i   (vld_s2),
      .op_s2_i   (op_s2),
      .op_i      (op_in),
      .vld_out_i (vld_s3),
      .a_i       (in_a[i*LW +: LW]),
      .b_i       (in_b[i*LW +: LW]),
      .res_o     (out_data[i*LW +: LW])
    );
  end

  assign out_valid = vld_s3;
endmodule

// File: tb/pmul_top_tb.sv
module pmul_top_tb;
  logic        clk, rst_n, in_valid, in_op, out_valid;
  logic [63:0] in_a, in_b, out_data;

  pmul_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [63:0] data;
    int          due;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic op);
    logic [63:0] r;
    for (int i = 0; i < 4; i++) begin
      logic signed [31:0] p;
      p = 32'(signed'(a[i*16 +: 16])) * 32'(signed'(b[i*16 +: 16]));
      r[i*16 +: 16] = op ? p[31:16] : p[15:0];
    end
    return r;
  endfunction

  task automatic issue(logic [63:0] a, logic [63:0] b, logic op, string tag);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    exp_q.push_back('{model(a, b, op), cyc + 3, tag});
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0; in_a = '0; in_b = '0; in_op = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R4 unexpected out_valid: got=1 exp=0 at cyc %0d", cyc);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (out_data !== e.data || cyc != e.due) begin
          bad++;
          $display("FAIL %s data got=%h exp=%h cyc got=%0d exp=%0d",
                   e.tag, out_data, e.data, cyc, e.due);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = 1'b0; in_a = '0; in_b = '0;
    repeat (4) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++; $display("FAIL R6 out_valid in reset got=%b exp=0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++; $display("FAIL R6 out_valid after reset got=%b exp=0", out_valid);
    end

    // R3 / R2 corner: min negative squared
    issue(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1'b1, "R3 minneg hi");
    issue(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1'b0, "R2 minneg lo");
    // all ones: -1 * -1
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R3 ones hi");
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R2 ones lo");
    // mixed corners per lane: R1
    issue(64'h7FFF_8000_FFFF_0001, 64'h8000_7FFF_0003_FFFF, 1'b1, "R1 mixed hi");
    issue(64'h7FFF_8000_FFFF_0001, 64'h8000_7FFF_0003_FFFF, 1'b0, "R1 mixed lo");
    idle(2);
    // R1: change only lane 2, others fixed
    issue(64'h1234_0000_5678_9ABC, 64'h4321_0000_8765_CBA9, 1'b1, "R1 lane2 zero");
    issue(64'h1234_7FFF_5678_9ABC, 64'h4321_8001_8765_CBA9, 1'b1, "R1 lane2 set");
    idle(4);
    // R5: alternating modes every cycle, back to back
    for (int k = 0; k < 40; k++)
      issue({$urandom, $urandom}, {$urandom, $urandom}, k[0], "R5 alternate");
    // R4: random bubbles
    for (int k = 0; k < 200; k++) begin
      if ($urandom_range(0, 2) == 0) idle(1);
      else issue({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R4 bubbles");
    end
    idle(6);
    total++;
    if (exp_q.size() != 0) begin
      bad++; $display("FAIL R4 results missing got=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R5 watchdog expired got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule